// File: doc/BRIEF.md
# Subtractive GCD Controller-Datapath Engine

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. It is split into a controller and a datapath. The controller is a six-state machine whose states follow the control-flow graph of the classic loop. In that loop, while the two values differ, the smaller value is subtracted from the larger one. The datapath holds one register for each loop variable. It also holds the two subtractors and produces the two comparison flags that steer the controller.

In each clock cycle the controller issues one encoded command. A decode table turns that command into a select value for each register's input multiplexer. Exactly one loop statement executes per clock. A caller presents both operands and pulses `start` while the engine is idle. It then waits for `done`, at which point `out_a` holds the result. A further `start` pulse returns the engine to idle, and the next `start` begins a new computation. An operand of zero short-circuits the loop and produces a zero result.

Top module: `gcd_fsmd`

## Requirements
- R1: While reset is asserted and right after it, `done` is 0 and `out_a` is 0.
- R2: While idle with `start` low, `done` stays 0 and `out_a` keeps its value.
- R3: A `start` seen while idle with both operands nonzero loads both registers. One cycle later `out_a` equals `in_a`.
- R4: When `done` is 1, `out_a` equals the greatest common divisor of the operands loaded at the last start.
- R5: With both operands nonzero and k the number of subtractions the loop performs, `done` rises exactly 2+3k cycles after the clock edge that sampled `start`.
- R6: Equal nonzero operands finish after 2 cycles with `out_a` equal to the operand.
- R7: If either operand is zero at start, `done` is 1 one cycle later and `out_a` is 0.
- R8: Once `done` is 1, it and `out_a` stay unchanged while `start` is low. A `start` pulse then clears `done` on the next cycle and returns to idle without loading, so a second `start` is needed to begin a new computation.
- R9: Changes on `in_a`, `in_b` and `start` while a computation runs have no effect on its result or its latency.
- R10: While the loop runs, `out_a` never increases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a computation when idle; leave the finished state when done |
| in_a | input | W | First operand (unsigned) |
| in_b | input | W | Second operand (unsigned) |
| out_a | output | W | Current content of the a register; the result when done |
| done | output | 1 | High while the engine sits in its finished state |

## Verification
The bench aims at operand pairs where the loop length is easy to get wrong. It uses equal values, coprime values, and a value of 1 against a large one, in both orders. A design that mixed up the subtraction direction or the comparison flag would give a wrong result or a wrong 2+3k latency. It also drives zero operands. A design without the short-circuit would never raise `done`, and the watchdog bound catches that. It wiggles the inputs and `start` during a run, which would expose any stray reload. It also checks that leaving the finished state does not reload the registers by itself.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  // Controller states, one per statement of the loop
  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_TEST  = 3'd1,
    ST_CMP   = 3'd2,
    ST_SUBA  = 3'd3,
    ST_SUBB  = 3'd4,
    ST_FIN   = 3'd5
  } state_e;

  // Commands from controller to datapath
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_LOAD  = 3'd1,
    CMD_AMB   = 3'd2,
    CMD_BMA   = 3'd3,
    CMD_CLEAR = 3'd4
  } cmd_e;

  // Per-register input select
  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_IN   = 2'd1,
    SEL_DIFF = 2'd2,
    SEL_ZERO = 2'd3
  } sel_e;

  localparam int unsigned NREG = 2;

endpackage

// File: rtl/gcd_rst_sync.sv
module gcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   flag_ne,
  input  logic   flag_gt,
  input  logic   in_zero,
  output cmd_e   cmd,
  output state_e state,
  output logic   done
);
  state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    cmd  = CMD_IDLE;
    case (st_q)
      ST_WAIT: begin
        if (start) begin
          if (in_zero) begin
            cmd  = CMD_CLEAR;
            st_d = ST_FIN;
          end else begin
            cmd  = CMD_LOAD;
            st_d = ST_TEST;
          end
        end
      end
      ST_TEST: st_d = flag_ne ? ST_CMP : ST_FIN;
      ST_CMP:  st_d = flag_gt ? ST_SUBA : ST_SUBB;
      ST_SUBA: begin
        cmd  = CMD_AMB;
        st_d = ST_TEST;
      end
      ST_SUBB: begin
        cmd  = CMD_BMA;
        st_d = ST_TEST;
      end
      ST_FIN:  if (start) st_d = ST_WAIT;
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT;
    else        st_q <= st_d;
  end

  assign state = st_q;
  assign done  = (st_q == ST_FIN);
endmodule

// File: rtl/gcd_cmd_table.sv
module gcd_cmd_table
  import gcd_pkg::*;
(
  input  cmd_e cmd,
  output sel_e sel [NREG]
);
  always_comb begin
    sel[0] = SEL_HOLD;
    sel[1] = SEL_HOLD;
    case (cmd)
      CMD_LOAD:  begin sel[0] = SEL_IN;   sel[1] = SEL_IN;   end
      CMD_AMB:   begin sel[0] = SEL_DIFF; sel[1] = SEL_HOLD; end
      CMD_BMA:   begin sel[0] = SEL_HOLD; sel[1] = SEL_DIFF; end
      CMD_CLEAR: begin sel[0] = SEL_ZERO; sel[1] = SEL_ZERO; end
      default:   begin sel[0] = SEL_HOLD; sel[1] = SEL_HOLD; end
    endcase
  end
endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  sel_e         sel [NREG],
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         flag_ne,
  output logic         flag_gt,
  output logic         in_zero
);
  logic [W-1:0] op_in [NREG];
  logic [W-1:0] reg_q [NREG];

  assign op_in[0] = in_a;
  assign op_in[1] = in_b;

  // Symmetric register slices: each subtracts its partner from itself
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int unsigned OTHER = NREG - 1 - i;
    logic [W-1:0] q, d, diff;
    logic         en;

    assign diff = q - reg_q[OTHER];
    assign en   = (sel[i] != SEL_HOLD);

    always_comb begin
      case (sel[i])
        SEL_IN:   d = op_in[i];
        SEL_DIFF: d = diff;
        SEL_ZERO: d = '0;
        default:  d = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign reg_q[i] = q;
  end

  assign a_q     = reg_q[0];
  assign b_q     = reg_q[1];
  assign flag_ne = (reg_q[0] != reg_q[1]);
  assign flag_gt = (reg_q[0] >  reg_q[1]);
  assign in_zero = (in_a == '0) || (in_b == '0);
endmodule

// File: rtl/gcd_fsmd.sv
module gcd_fsmd
  import gcd_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_a,
  output logic         done
);
  logic         rst_sync_n;
  cmd_e         cmd;
  state_e       st;
  sel_e         sel [NREG];
  logic [W-1:0] a_q, b_q;
  logic         flag_ne, flag_gt, in_zero;

  gcd_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gcd_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .flag_ne (flag_ne),
    .flag_gt (flag_gt),
    .in_zero (in_zero),
    .cmd     (cmd),
    .state   (st),
    .done    (done)
  );

  gcd_cmd_table u_tab (
    .cmd (cmd),
    .sel (sel)
  );

  gcd_dpath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_a    (in_a),
    .in_b    (in_b),
    .sel     (sel),
    .a_q     (a_q),
    .b_q     (b_q),
    .flag_ne (flag_ne),
    .flag_gt (flag_gt),
    .in_zero (in_zero)
  );

  assign out_a = a_q;
endmodule

// File: rtl/gcd_fsmd_chk.sv
module gcd_fsmd_chk
  import gcd_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] out_a,
  input logic [W-1:0] b_q,
  input logic         done,
  input state_e       st
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !start) |=> (!done && $stable(out_a)));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && start && in_a != '0 && in_b != '0) |=> (out_a == $past(in_a)));

  // R4
  result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_a == b_q));

  // R7
  zero_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && start && (in_a == '0 || in_b == '0)) |=> (done && out_a == '0));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(out_a)));

  // R8
  done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && $stable(out_a)));

  // R10
  no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TEST || st == ST_CMP || st == ST_SUBA || st == ST_SUBB) |=> (out_a <= $past(out_a)));
endmodule

bind gcd_fsmd gcd_fsmd_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .start (start),
  .in_a  (in_a),
  .in_b  (in_b),
  .out_a (out_a),
  .b_q   (b_q),
  .done  (done),
  .st    (st)
);

// File: tb/test_gcd_fsmd.sv
module test_gcd_fsmd;
  localparam int unsigned W = 16;
  localparam int LIMIT = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] in_a, in_b;
  logic [W-1:0] out_a;
  logic         done;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  gcd_fsmd #(.W(W)) i_gcd_fsmd (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .in_a  (in_a),
    .in_b  (in_b),
    .out_a (out_a),
    .done  (done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_gcd(input int x, input int y);
    int p = x, q = y, t;
    while (q != 0) begin t = p % q; p = q; q = t; end
    return p;
  endfunction

  function automatic int ref_subs(input int x, input int y);
    int p = x, q = y, k = 0;
    while (p != q) begin
      if (p > q) p = p - q; else q = q - p;
      k++;
    end
    return k;
  endfunction

  // Leave the finished state: one start pulse, no reload (R8)
  task automatic t_leave();
    logic [W-1:0] held;
    held = out_a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 done cleared", done, 0);
    check("R8 no reload on exit", out_a, held);
    @(negedge clk);
    check("R8 idle keeps value", out_a, held);
  endtask

  // Full run from idle; checks load, result and latency
  task automatic t_run(input int a, input int b, input bit disturb);
    int cnt = 1;
    int exp_lat;
    in_a = W'(a); in_b = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (a != 0 && b != 0) check("R3 load", out_a, a);
    if (disturb) begin
      // R9: noise on inputs and start mid-run
      in_a = W'(a + 5); in_b = 16'd0; start = 1'b1;
      @(negedge clk); cnt++;
      in_a = 16'd0; in_b = W'(b + 3);
      @(negedge clk); cnt++;
      start = 1'b0;
    end
    while (!done && cnt < LIMIT) begin
      @(negedge clk);
      cnt++;
    end
    if (a == 0 || b == 0) begin
      check("R7 zero latency", cnt, 1);
      check("R7 zero result", out_a, 0);
    end else begin
      exp_lat = 2 + 3 * ref_subs(a, b);
      if (disturb) begin
        check("R9 result unaffected", out_a, ref_gcd(a, b));
        check("R9 latency unaffected", cnt, exp_lat);
      end else if (a == b) begin
        check("R6 equal latency", cnt, 2);
        check("R6 equal result", out_a, a);
      end else begin
        check("R4 gcd result", out_a, ref_gcd(a, b));
        check("R5 latency", cnt, exp_lat);
      end
    end
    t_leave();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 out_a in reset", out_a, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 out_a after reset", out_a, 0);
  endtask

  task automatic t_idle();
    logic [W-1:0] held;
    held = out_a;
    in_a = 16'd77; in_b = 16'd33;
    repeat (5) @(negedge clk);
    check("R2 idle done", done, 0);
    check("R2 idle out_a", out_a, held);
  endtask

  task automatic t_done_hold();
    logic [W-1:0] held;
    in_a = 16'd21; in_b = 16'd14;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    held = out_a;
    in_a = 16'd9; in_b = 16'd0;
    repeat (6) @(negedge clk);
    check("R8 done held", done, 1);
    check("R8 result held", out_a, held);
    check("R4 gcd 21 14", held, 7);
    t_leave();
  endtask

  initial begin
    #(8 * 190000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_run(48, 18, 1'b0);
    t_run(18, 48, 1'b0);
    t_run(13, 17, 1'b0);
    t_run(7, 7, 1'b0);
    t_run(65535, 65535, 1'b0);
    t_run(1, 1000, 1'b0);
    t_run(1000, 1, 1'b0);
    t_run(40000, 30000, 1'b0);
    t_run(1024, 3, 1'b0);
    t_run(0, 5, 1'b0);
    t_run(5, 0, 1'b0);
    t_run(0, 0, 1'b0);
    t_run(48, 18, 1'b1);
    t_done_hold();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule